// File: doc/BRIEF.md
# PLL Divider Select and Staging

This block sits on the register side of a clock generator. It chooses the frequency selection that drives each of two PLLs, one for the processor clock and one for the AGP/PCI clock, and it stages a 10-bit feedback divider value for each PLL that software writes one byte at a time. A one-cycle write strobe carries an address and a data byte. Strap pins are sampled while reset is held, and the captured value supplies the default processor band.

Each PLL's divider value is split across two byte registers. The upper bits go only into a shadow copy. When software writes the low byte while divider programming is enabled for that PLL, the block forms the full 10-bit value in one step and raises a single-cycle load pulse so that the PLL can relock. When programming is disabled, a low-byte write leaves the committed divider unchanged. The analog PLLs, the frequency tables and the serial bus decoding lie outside this block.

Top module: `pll_ndiv_stage`

## Requirements
- R1: After reset both committed dividers read 0x12A, both load pulses are low, ap_fixed_o is 1, ap_sel_o is 000, and cpu_sel_o is {1'b0, strap, 3'b000}, where strap is the value fs_strap_i held during reset.
- R2: fs_strap_i is captured only while rst is high. A change on fs_strap_i after reset has no effect on any output.
- R3: Address 0 is the processor control byte: bit 0 is the software-source flag, bits 3:1 are the band, bits 6:4 are the code, and bit 7 enables divider programming. cpu_sel_o[2:0] always equals the code. cpu_sel_o[5:3] equals the written band when the flag is 1, and {1'b0, strap} when the flag is 0.
- R4: Address 3 is the AGP/PCI control byte: bit 0 is the software-source flag, bits 3:1 are the code, and bit 4 enables divider programming. When the flag is 0, ap_fixed_o is 1 (fixed 66/33 MHz) and ap_sel_o is 000. When the flag is 1, ap_fixed_o is 0 and ap_sel_o equals the code.
- R5: A write to an upper-bits address (1 for the processor PLL, 4 for the AGP/PCI PLL) stores data bits 1:0 in the shadow copy only. The committed divider and the load pulse do not change.
- R6: A low-byte write (address 2 or 5) while that PLL's programming enable is 1 makes the committed divider equal {shadow upper bits, data byte} in the next cycle, and raises that PLL's load pulse for exactly that one cycle.
- R7: A low-byte write while that PLL's programming enable is 0 changes neither the committed divider nor the load pulse.
- R8: Writes to one PLL's addresses never change the other PLL's selection, divider or load pulse.
- R9: Writes to addresses 6 and 7 change no output.
- R10: Low-byte writes on consecutive cycles each commit their own value, and the load pulse stays high in each of the cycles that follow them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap is captured while it is high |
| fs_strap_i | input | 2 | Hardware strap selecting the default processor band |
| wr_en_i | input | 1 | One-cycle register write strobe |
| wr_addr_i | input | 3 | Register address of the write |
| wr_data_i | input | 8 | Data byte of the write |
| cpu_sel_o | output | 6 | Active processor selection: [5:3] band, [2:0] code |
| ap_fixed_o | output | 1 | 1 when the AGP/PCI PLL runs at fixed 66/33 MHz |
| ap_sel_o | output | 3 | Active AGP/PCI code (000 when fixed) |
| cpu_n_o | output | N_W | Committed processor PLL divider |
| cpu_n_load_o | output | 1 | One-cycle pulse on each processor divider commit |
| ap_n_o | output | N_W | Committed AGP/PCI PLL divider |
| ap_n_load_o | output | 1 | One-cycle pulse on each AGP/PCI divider commit |

## Verification
A commit and the next register update can fall in the same cycle: a low-byte write on the cycle right after an upper-bits write must pick up the shadow value written one edge earlier, and the load pulse from one commit overlaps the cycle in which the next write is taken. The bench provokes this with write bursts that have no idle cycle between them, on one PLL and then across both PLLs. A behavioural model, updated on each clock, judges every output in every cycle, so a stale shadow, a merged pulse or a value landing on the wrong PLL shows up in the cycle where it occurs.

// File: rtl/pll_sel_pkg.sv
package pll_sel_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CPU_CTL = 3'd0,
        A_CPU_NHI = 3'd1,
        A_CPU_NLO = 3'd2,
        A_AP_CTL  = 3'd3,
        A_AP_NHI  = 3'd4,
        A_AP_NLO  = 3'd5
    } reg_addr_e;

    // processor control byte, MSB first
    typedef struct packed {
        logic       nprog_en;
        logic [2:0] code;
        logic [2:0] band;
        logic       src_sw;
    } cpu_ctl_t;

    // AGP/PCI control byte, MSB first
    typedef struct packed {
        logic [2:0] unused;
        logic       nprog_en;
        logic [2:0] code;
        logic       src_sw;
    } ap_ctl_t;

    typedef struct packed {
        logic [2:0] band;
        logic [2:0] code;
    } cpu_sel_t;

    typedef struct packed {
        logic       fixed;
        logic [2:0] code;
    } ap_sel_t;

    localparam int N_CH   = 2;
    localparam int CH_CPU = 0;
    localparam int CH_AP  = 1;

    function automatic logic [2:0] strap_band(input logic [1:0] fs);
        return {1'b0, fs};
    endfunction

endpackage

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fs_strap_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output cpu_ctl_t          cpu_ctl_o,
    output ap_ctl_t           ap_ctl_o,
    output logic [1:0]        strap_o,
    output logic [N_CH-1:0]   hi_we_o,
    output logic [N_CH-1:0]   lo_we_o,
    output logic [N_CH-1:0]   nprog_en_o
);

    cpu_ctl_t   cpu_ctl_q;
    ap_ctl_t    ap_ctl_q;
    logic [1:0] strap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_ctl_q <= '0;
            ap_ctl_q  <= '0;
            strap_q   <= fs_strap_i;
        end else if (wr_en_i) begin
            if (wr_addr_i == A_CPU_CTL) cpu_ctl_q <= cpu_ctl_t'(wr_data_i);
            if (wr_addr_i == A_AP_CTL)  ap_ctl_q  <= ap_ctl_t'(wr_data_i);
        end
    end

    always_comb begin
        hi_we_o[CH_CPU] = wr_en_i && (wr_addr_i == A_CPU_NHI);
        lo_we_o[CH_CPU] = wr_en_i && (wr_addr_i == A_CPU_NLO);
        hi_we_o[CH_AP]  = wr_en_i && (wr_addr_i == A_AP_NHI);
        lo_we_o[CH_AP]  = wr_en_i && (wr_addr_i == A_AP_NLO);
        nprog_en_o[CH_CPU] = cpu_ctl_q.nprog_en;
        nprog_en_o[CH_AP]  = ap_ctl_q.nprog_en;
    end

    assign cpu_ctl_o = cpu_ctl_q;
    assign ap_ctl_o  = ap_ctl_q;
    assign strap_o   = strap_q;

endmodule

// File: rtl/pll_n_stage.sv
module pll_n_stage
    import pll_sel_pkg::*;
#(
    parameter int          N_W   = 10,
    parameter logic [N_W-1:0] N_RST = 10'h12A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_we_i,
    input  logic              lo_we_i,
    input  logic              nprog_en_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [N_W-1:0]    n_o,
    output logic              load_o
);

    localparam int HI_W = N_W - BYTE_W;

    logic [HI_W-1:0] shadow_hi_q;
    logic [N_W-1:0]  n_q;
    logic            load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_hi_q <= N_RST[N_W-1:BYTE_W];
            n_q         <= N_RST;
            load_q      <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (hi_we_i) shadow_hi_q <= wdata_i[HI_W-1:0];
            if (lo_we_i && nprog_en_i) begin
                n_q    <= {shadow_hi_q, wdata_i};
                load_q <= 1'b1;
            end
        end
    end

    assign n_o    = n_q;
    assign load_o = load_q;

endmodule

// File: rtl/pll_src_mux.sv
module pll_src_mux
    import pll_sel_pkg::*;
(
    input  cpu_ctl_t   cpu_ctl_i,
    input  ap_ctl_t    ap_ctl_i,
    input  logic [1:0] strap_i,
    output cpu_sel_t   cpu_sel_o,
    output ap_sel_t    ap_sel_o
);

    always_comb begin
        cpu_sel_o.code = cpu_ctl_i.code;
        cpu_sel_o.band = cpu_ctl_i.src_sw ? cpu_ctl_i.band : strap_band(strap_i);
        ap_sel_o.fixed = !ap_ctl_i.src_sw;
        ap_sel_o.code  = ap_ctl_i.src_sw ? ap_ctl_i.code : 3'b000;
    end

endmodule

// File: rtl/pll_ndiv_stage.sv
module pll_ndiv_stage
    import pll_sel_pkg::*;
#(
    parameter int             N_W   = 10,
    parameter logic [N_W-1:0] N_RST = 10'h12A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fs_strap_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [5:0]        cpu_sel_o,
    output logic              ap_fixed_o,
    output logic [2:0]        ap_sel_o,
    output logic [N_W-1:0]    cpu_n_o,
    output logic              cpu_n_load_o,
    output logic [N_W-1:0]    ap_n_o,
    output logic              ap_n_load_o
);

    cpu_ctl_t        cpu_ctl;
    ap_ctl_t         ap_ctl;
    logic [1:0]      strap;
    logic [N_CH-1:0] hi_we, lo_we, nprog_en, load;
    logic [N_W-1:0]  n_val [N_CH];
    cpu_sel_t        cpu_sel;
    ap_sel_t         ap_sel;

    pll_ctl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .fs_strap_i (fs_strap_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .cpu_ctl_o  (cpu_ctl),
        .ap_ctl_o   (ap_ctl),
        .strap_o    (strap),
        .hi_we_o    (hi_we),
        .lo_we_o    (lo_we),
        .nprog_en_o (nprog_en)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        pll_n_stage #(.N_W(N_W), .N_RST(N_RST)) u_stage (
            .clk        (clk),
            .rst        (rst),
            .hi_we_i    (hi_we[c]),
            .lo_we_i    (lo_we[c]),
            .nprog_en_i (nprog_en[c]),
            .wdata_i    (wr_data_i),
            .n_o        (n_val[c]),
            .load_o     (load[c])
        );
    end

    pll_src_mux u_mux (
        .cpu_ctl_i (cpu_ctl),
        .ap_ctl_i  (ap_ctl),
        .strap_i   (strap),
        .cpu_sel_o (cpu_sel),
        .ap_sel_o  (ap_sel)
    );

    assign cpu_sel_o    = cpu_sel;
    assign ap_fixed_o   = ap_sel.fixed;
    assign ap_sel_o     = ap_sel.code;
    assign cpu_n_o      = n_val[CH_CPU];
    assign cpu_n_load_o = load[CH_CPU];
    assign ap_n_o       = n_val[CH_AP];
    assign ap_n_load_o  = load[CH_AP];

endmodule

// File: rtl/pll_ndiv_stage_chk.sv
module pll_ndiv_stage_chk #(
    parameter int N_W = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en_i,
    input logic [2:0]     wr_addr_i,
    input logic [7:0]     wr_data_i,
    input logic [5:0]     cpu_sel_o,
    input logic           ap_fixed_o,
    input logic [2:0]     ap_sel_o,
    input logic [N_W-1:0] cpu_n_o,
    input logic           cpu_n_load_o,
    input logic [N_W-1:0] ap_n_o,
    input logic           ap_n_load_o
);

    assert_hi_shadow_only_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (wr_addr_i == 3'd1)) |=> (!cpu_n_load_o && $stable(cpu_n_o)));

    assert_load_from_lo_write_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_n_load_o |-> ($past(wr_en_i) && $past(wr_addr_i) == 3'd2
                          && cpu_n_o[7:0] == $past(wr_data_i)));

    assert_n_moves_with_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_n_o != $past(cpu_n_o)) |-> cpu_n_load_o);

    assert_fixed_mode_code_R4: assert property (@(posedge clk) disable iff (rst)
        ap_fixed_o |-> (ap_sel_o == 3'b000));

    assert_ap_write_leaves_cpu_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i >= 3'd3 && wr_addr_i <= 3'd5)
        |=> ($stable(cpu_n_o) && !cpu_n_load_o && $stable(cpu_sel_o)));

    assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i >= 3'd6)
        |=> ($stable(cpu_n_o) && $stable(ap_n_o) && $stable(cpu_sel_o)
             && $stable(ap_sel_o) && $stable(ap_fixed_o)
             && !cpu_n_load_o && !ap_n_load_o));

endmodule

bind pll_ndiv_stage pll_ndiv_stage_chk #(.N_W(N_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .cpu_sel_o    (cpu_sel_o),
    .ap_fixed_o   (ap_fixed_o),
    .ap_sel_o     (ap_sel_o),
    .cpu_n_o      (cpu_n_o),
    .cpu_n_load_o (cpu_n_load_o),
    .ap_n_o       (ap_n_o),
    .ap_n_load_o  (ap_n_load_o)
);

// File: tb/pll_ndiv_stage_tb_top.sv
module pll_ndiv_stage_tb_top;

    localparam int N_W = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [1:0]     fs_strap_i = 2'b10;
    logic           wr_en_i = 1'b0;
    logic [2:0]     wr_addr_i = '0;
    logic [7:0]     wr_data_i = '0;
    logic [5:0]     cpu_sel_o;
    logic           ap_fixed_o;
    logic [2:0]     ap_sel_o;
    logic [N_W-1:0] cpu_n_o, ap_n_o;
    logic           cpu_n_load_o, ap_n_load_o;

    always #4 clk = ~clk;

    pll_ndiv_stage #(.N_W(N_W)) dut_i (.*);

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    chk_on = 0;

    // behavioural reference state
    int m_strap, m_cctl, m_actl, m_chi, m_ahi, m_cn, m_an;
    bit m_cp, m_ap;

    always @(posedge clk) begin
        chk_on <= 1'b1;
        if (rst) begin
            m_strap = fs_strap_i; m_cctl = 0; m_actl = 0;
            m_chi = 1; m_ahi = 1; m_cn = 'h12A; m_an = 'h12A;
            m_cp = 0; m_ap = 0;
        end else begin
            m_cp = 0; m_ap = 0;
            if (wr_en_i) begin
                case (int'(wr_addr_i))
                    0: m_cctl = wr_data_i;
                    1: m_chi = wr_data_i % 4;
                    2: if (m_cctl / 128 % 2 == 1) begin
                           m_cn = m_chi * 256 + wr_data_i; m_cp = 1;
                       end
                    3: m_actl = wr_data_i;
                    4: m_ahi = wr_data_i % 4;
                    5: if (m_actl / 16 % 2 == 1) begin
                           m_an = m_ahi * 256 + wr_data_i; m_ap = 1;
                       end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            int band, code, exp_sel;
            code = m_cctl / 16 % 8;
            band = (m_cctl % 2 == 1) ? (m_cctl / 2 % 8) : m_strap;
            exp_sel = band * 8 + code;
            check("cpu_sel", int'(cpu_sel_o), exp_sel);
            check("ap_fixed", int'(ap_fixed_o), (m_actl % 2 == 1) ? 0 : 1);
            check("ap_sel", int'(ap_sel_o), (m_actl % 2 == 1) ? (m_actl / 2 % 8) : 0);
            check("cpu_n", int'(cpu_n_o), m_cn);
            check("cpu_load", int'(cpu_n_load_o), int'(m_cp));
            check("ap_n", int'(ap_n_o), m_an);
            check("ap_load", int'(ap_n_load_o), int'(m_ap));
        end
    end

    task automatic wr(input int a, input int d);
        wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 8'(d);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1"; idle(2);
        cur_req = "R2"; fs_strap_i = 2'b01; idle(3);
        cur_req = "R3"; wr(0, 'h5D); idle(1); wr(0, 'h50); idle(2);
        cur_req = "R4"; wr(3, 'h0B); idle(1); wr(3, 'h0A); idle(2);
        cur_req = "R5"; wr(1, 'hFE); idle(2);
        cur_req = "R7"; wr(2, 'h33); idle(2);
        cur_req = "R6"; wr(0, 'h80); wr(2, 'h44); idle(2);
        cur_req = "R10"; wr(1, 'h03); wr(2, 'h01); wr(2, 'hFF); wr(1, 'h00); wr(2, 'h7E); idle(2);
        cur_req = "R8"; wr(3, 'h10); wr(4, 'h00); wr(5, 'h99); wr(2, 'h12); wr(5, 'h55); idle(2);
        cur_req = "R9"; wr(6, 'hFF); wr(7, 'hFF); idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule